// File: doc/BRIEF.md
# Configurable GPIO Pin Multiplexer

This block sits between a bank of I/O pads and the peripherals of a chip. For each pad, a 2-bit function field picks the source of the pad's output value and output-enable. The source is either plain GPIO or one of three alternate peripheral functions. A per-pad drive mode then shapes those two signals for the pad cell: released (high impedance), push-pull or open-drain. The block also drives a pull-up enable and a pull-down enable line for every pad.

Routing in the input direction is turned around. Each peripheral input function owns a selector that names exactly one source pad, so a function input never has more than one driver. Every pad input can go through a debouncer clocked by a programmable sample-rate divider, or it can bypass the debouncer. When bypassed, the pad-to-function path is purely combinational.

Configuration comes in through a simple synchronous write port: one address per pad, one per input function and one for the divider. A write takes effect from the clock edge that accepts it.

Top module: `pinMuxTop`

## Requirements
- R1: A write with `wrEn` high at address p (0 to NUM_PADS-1) loads the pad word. The word's bits [1:0] are the function select: 0 picks `gpioOut[p]`/`gpioOe[p]`, and k = 1..3 picks `altOut`/`altOe` bit (k-1)*NUM_PADS+p. The pad outputs reflect the new word once the write edge has passed.
- R2: Drive mode 1 (pad word bits [3:2] = 01) is push-pull: `padOut` equals the selected output value and `padOe` equals the selected enable.
- R3: Drive mode 2 (bits [3:2] = 10) is open-drain: `padOut` is 0 and `padOe` is high only when the selected enable is 1 and the selected output value is 0.
- R4: Drive modes 0 and 3 release the pad: `padOe` and `padOut` are both 0, whatever the selected function does.
- R5: `padPu[p]` equals pad word bit 4. `padPd[p]` equals bit 5 while bit 4 is 0, and is forced to 0 while bit 4 is 1.
- R6: A write at address NUM_PADS+f sets the source pad of function input f to data bits [PAD_W-1:0]. After that, `funcIn[f]` follows the (possibly debounced) input of that pad.
- R7: A function input that has never been written since reset reads 0, regardless of the pad levels.
- R8: With pad word bit 6 at 0, `gpioIn[p]` and any function input sourced from pad p follow `padIn[p]` combinationally, with no clock edge in between.
- R9: With pad word bit 6 at 1, the pad input is sampled on every divider tick. The filtered value changes only when three consecutive samples agree and differ from it. Address NUM_PADS+NUM_IN holds the divider value D, which gives one tick every D+1 cycles.
- R10: After reset, every pad word and the divider are 0. So every pad is in GPIO mode and released, with no pulls and no debounce. Every function input source points to pad 0 and is gated to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Configuration write strobe |
| wrAddr | input | ADDR_W | Configuration write address |
| wrData | input | DATA_W | Configuration write data |
| gpioOut | input | NUM_PADS | GPIO output value per pad |
| gpioOe | input | NUM_PADS | GPIO output-enable per pad |
| altOut | input | 3*NUM_PADS | Alternate function output values, function-major |
| altOe | input | 3*NUM_PADS | Alternate function output-enables, function-major |
| padIn | input | NUM_PADS | Levels seen at the pads |
| padOut | output | NUM_PADS | Value to the pad drivers |
| padOe | output | NUM_PADS | Driver enable to the pads |
| padPu | output | NUM_PADS | Pull-up enable per pad |
| padPd | output | NUM_PADS | Pull-down enable per pad |
| gpioIn | output | NUM_PADS | Pad input after optional debounce |
| funcIn | output | NUM_IN | Peripheral function inputs, one source pad each |

## Verification
A wrong function select or drive-mode decode appears on `padOut`/`padOe` as soon as the write edge has passed. The bench makes it visible by giving the unselected functions the inverse of the selected one's values. A wrong input selector or a missing gate shows as a wrong `funcIn` level within the same cycle the pads change. A debouncer fault has a longer reach: its history registers are hidden, so a corrupted sample shows only after the next two or three divider ticks. The bench therefore checks both the earliest cycle a change may appear and the latest cycle by which it must appear.

// File: rtl/pinMuxPkg.sv
package pinMuxPkg;
  localparam int NUM_ALT = 3;

  typedef struct packed {
    logic       dbEn;
    logic       pullDown;
    logic       pullUp;
    logic [1:0] drvMode;
    logic [1:0] funcSel;
  } padCfg_t;

  localparam logic [1:0] DRV_HIZ  = 2'd0;
  localparam logic [1:0] DRV_PP   = 2'd1;
  localparam logic [1:0] DRV_OD   = 2'd2;

  typedef struct packed {
    logic sampleTick;
  } ctrlStrobe_t;
endpackage

// File: rtl/pinDebounce.sv
module pinDebounce (
  input  logic clk,
  input  logic rst,
  input  logic sampleTick,
  input  logic rawIn,
  output logic stableOut
);
  logic [1:0] hist;
  logic       agree;

  assign agree = (hist[1] == hist[0]) && (hist[0] == rawIn);

  always_ff @(posedge clk) begin
    if (rst) begin
      hist      <= 2'b00;
      stableOut <= 1'b0;
    end else if (sampleTick) begin
      hist <= {hist[0], rawIn};
      if (agree) stableOut <= rawIn;
    end
  end
endmodule

// File: rtl/pinMuxCtrl.sv
module pinMuxCtrl
  import pinMuxPkg::*;
#(
  parameter int NUM_PADS = 4,
  parameter int NUM_IN   = 4,
  parameter int DIV_W    = 8,
  parameter int DATA_W   = 8,
  parameter int PAD_W    = 2,
  parameter int ADDR_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output padCfg_t           padCfg [NUM_PADS],
  output logic [PAD_W-1:0]  inSel  [NUM_IN],
  output logic [NUM_IN-1:0] inValid,
  output ctrlStrobe_t       strobe
);
  localparam int DIV_ADDR = NUM_PADS + NUM_IN;

  logic [DIV_W-1:0] divQ;
  logic [DIV_W-1:0] divCnt;
  logic             tick;

  for (genvar p = 0; p < NUM_PADS; p++) begin : gPadReg
    always_ff @(posedge clk) begin
      if (rst) padCfg[p] <= '0;
      else if (wrEn && wrAddr == ADDR_W'(p)) padCfg[p] <= padCfg_t'(wrData[6:0]);
    end
  end

  for (genvar f = 0; f < NUM_IN; f++) begin : gInReg
    always_ff @(posedge clk) begin
      if (rst) begin
        inSel[f]   <= '0;
        inValid[f] <= 1'b0;
      end else if (wrEn && wrAddr == ADDR_W'(NUM_PADS + f)) begin
        inSel[f]   <= wrData[PAD_W-1:0];
        inValid[f] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) divQ <= '0;
    else if (wrEn && wrAddr == ADDR_W'(DIV_ADDR)) divQ <= wrData[DIV_W-1:0];
  end

  assign tick = (divCnt >= divQ);

  always_ff @(posedge clk) begin
    if (rst) divCnt <= '0;
    else if (tick) divCnt <= '0;
    else divCnt <= divCnt + 1'b1;
  end

  assign strobe.sampleTick = tick;
endmodule

// File: rtl/pinMuxData.sv
module pinMuxData
  import pinMuxPkg::*;
#(
  parameter int NUM_PADS = 4,
  parameter int NUM_IN   = 4,
  parameter int PAD_W    = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  ctrlStrobe_t                strobe,
  input  padCfg_t                    padCfg [NUM_PADS],
  input  logic [PAD_W-1:0]           inSel  [NUM_IN],
  input  logic [NUM_IN-1:0]          inValid,
  input  logic [NUM_PADS-1:0]        gpioOut,
  input  logic [NUM_PADS-1:0]        gpioOe,
  input  logic [NUM_ALT*NUM_PADS-1:0] altOut,
  input  logic [NUM_ALT*NUM_PADS-1:0] altOe,
  input  logic [NUM_PADS-1:0]        padIn,
  output logic [NUM_PADS-1:0]        padOut,
  output logic [NUM_PADS-1:0]        padOe,
  output logic [NUM_PADS-1:0]        padPu,
  output logic [NUM_PADS-1:0]        padPd,
  output logic [NUM_PADS-1:0]        gpioIn,
  output logic [NUM_IN-1:0]          funcIn
);
  logic [NUM_PADS-1:0] filtered;

  for (genvar p = 0; p < NUM_PADS; p++) begin : gPad
    logic [NUM_ALT:0] candOut, candOe;
    logic             fnOut, fnOe, dbOut;

    assign candOut[0] = gpioOut[p];
    assign candOe[0]  = gpioOe[p];
    for (genvar a = 0; a < NUM_ALT; a++) begin : gAlt
      assign candOut[a+1] = altOut[a*NUM_PADS + p];
      assign candOe[a+1]  = altOe[a*NUM_PADS + p];
    end

    assign fnOut = candOut[padCfg[p].funcSel];
    assign fnOe  = candOe[padCfg[p].funcSel];

    always_comb begin
      case (padCfg[p].drvMode)
        DRV_PP: begin
          padOut[p] = fnOut;
          padOe[p]  = fnOe;
        end
        DRV_OD: begin
          padOut[p] = 1'b0;
          padOe[p]  = fnOe & ~fnOut;
        end
        default: begin
          padOut[p] = 1'b0;
          padOe[p]  = 1'b0;
        end
      endcase
    end

    assign padPu[p] = padCfg[p].pullUp;
    assign padPd[p] = padCfg[p].pullDown & ~padCfg[p].pullUp;

    pinDebounce uDb (
      .clk        (clk),
      .rst        (rst),
      .sampleTick (strobe.sampleTick),
      .rawIn      (padIn[p]),
      .stableOut  (dbOut)
    );

    assign filtered[p] = padCfg[p].dbEn ? dbOut : padIn[p];
  end

  assign gpioIn = filtered;

  for (genvar f = 0; f < NUM_IN; f++) begin : gFunc
    assign funcIn[f] = inValid[f] & filtered[inSel[f]];
  end
endmodule

// File: rtl/pinMuxTop.sv
module pinMuxTop
  import pinMuxPkg::*;
#(
  parameter int NUM_PADS = 4,
  parameter int NUM_IN   = 4,
  parameter int DIV_W    = 8,
  localparam int PAD_W   = (NUM_PADS > 1) ? $clog2(NUM_PADS) : 1,
  localparam int ADDR_W  = $clog2(NUM_PADS + NUM_IN + 1),
  localparam int DATA_W  = (DIV_W > 7) ? DIV_W : 7
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wrEn,
  input  logic [ADDR_W-1:0]           wrAddr,
  input  logic [DATA_W-1:0]           wrData,
  input  logic [NUM_PADS-1:0]         gpioOut,
  input  logic [NUM_PADS-1:0]         gpioOe,
  input  logic [3*NUM_PADS-1:0]       altOut,
  input  logic [3*NUM_PADS-1:0]       altOe,
  input  logic [NUM_PADS-1:0]         padIn,
  output logic [NUM_PADS-1:0]         padOut,
  output logic [NUM_PADS-1:0]         padOe,
  output logic [NUM_PADS-1:0]         padPu,
  output logic [NUM_PADS-1:0]         padPd,
  output logic [NUM_PADS-1:0]         gpioIn,
  output logic [NUM_IN-1:0]           funcIn
);
  padCfg_t           padCfgQ [NUM_PADS];
  logic [PAD_W-1:0]  inSelQ  [NUM_IN];
  logic [NUM_IN-1:0] inValidQ;
  ctrlStrobe_t       strobe;

  pinMuxCtrl #(
    .NUM_PADS(NUM_PADS), .NUM_IN(NUM_IN), .DIV_W(DIV_W),
    .DATA_W(DATA_W), .PAD_W(PAD_W), .ADDR_W(ADDR_W)
  ) uCtrl (
    .clk     (clk),
    .rst     (rst),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .padCfg  (padCfgQ),
    .inSel   (inSelQ),
    .inValid (inValidQ),
    .strobe  (strobe)
  );

  pinMuxData #(
    .NUM_PADS(NUM_PADS), .NUM_IN(NUM_IN), .PAD_W(PAD_W)
  ) uData (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .padCfg  (padCfgQ),
    .inSel   (inSelQ),
    .inValid (inValidQ),
    .gpioOut (gpioOut),
    .gpioOe  (gpioOe),
    .altOut  (altOut),
    .altOe   (altOe),
    .padIn   (padIn),
    .padOut  (padOut),
    .padOe   (padOe),
    .padPu   (padPu),
    .padPd   (padPd),
    .gpioIn  (gpioIn),
    .funcIn  (funcIn)
  );
endmodule

// File: rtl/pinMuxChecker.sv
module pinMuxChecker
  import pinMuxPkg::*;
#(
  parameter int NUM_PADS = 4,
  parameter int NUM_IN   = 4
) (
  input logic                clk,
  input logic                rst,
  input padCfg_t             padCfgQ [NUM_PADS],
  input logic [NUM_IN-1:0]   inValidQ,
  input ctrlStrobe_t         strobe,
  input logic [NUM_PADS-1:0] padOut,
  input logic [NUM_PADS-1:0] padOe,
  input logic [NUM_PADS-1:0] padPu,
  input logic [NUM_PADS-1:0] padPd,
  input logic [NUM_PADS-1:0] gpioIn,
  input logic [NUM_IN-1:0]   funcIn
);
  for (genvar p = 0; p < NUM_PADS; p++) begin : gPadChk
    AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (rst)
      (padCfgQ[p].drvMode == DRV_OD && padOe[p]) |-> !padOut[p]); // R3

    AST_HIZ_RELEASED: assert property (@(posedge clk) disable iff (rst)
      (padCfgQ[p].drvMode == 2'd0 || padCfgQ[p].drvMode == 2'd3) |-> !padOe[p]); // R4

    AST_PULL_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
      !(padPu[p] && padPd[p])); // R5

    AST_DB_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
      (padCfgQ[p].dbEn && $past(padCfgQ[p].dbEn) && !$past(strobe.sampleTick))
        |-> $stable(gpioIn[p])); // R9
  end

  for (genvar f = 0; f < NUM_IN; f++) begin : gFuncChk
    AST_UNWRITTEN_GATED: assert property (@(posedge clk) disable iff (rst)
      !inValidQ[f] |-> !funcIn[f]); // R7
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (padOe == '0 && padPu == '0 && padPd == '0 && funcIn == '0)); // R10
endmodule

bind pinMuxTop pinMuxChecker #(.NUM_PADS(NUM_PADS), .NUM_IN(NUM_IN)) uChk (
  .clk      (clk),
  .rst      (rst),
  .padCfgQ  (padCfgQ),
  .inValidQ (inValidQ),
  .strobe   (strobe),
  .padOut   (padOut),
  .padOe    (padOe),
  .padPu    (padPu),
  .padPd    (padPd),
  .gpioIn   (gpioIn),
  .funcIn   (funcIn)
);

// File: tb/tb_pinMuxTop.sv
module tb_pinMuxTop;
  localparam int P  = 4;
  localparam int NI = 4;
  localparam int AW = 4;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic [P-1:0]  gpioOut = '0, gpioOe = '0, padIn = '0;
  logic [3*P-1:0] altOut = '0, altOe = '0;
  logic [P-1:0]  padOut, padOe, padPu, padPd, gpioIn;
  logic [NI-1:0] funcIn;

  int nChecks = 0;
  int nFail   = 0;

  always #4 clk = ~clk;

  pinMuxTop #(.NUM_PADS(P), .NUM_IN(NI), .DIV_W(8)) dut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .gpioOut(gpioOut), .gpioOe(gpioOe), .altOut(altOut), .altOe(altOe),
    .padIn(padIn), .padOut(padOut), .padOe(padOe), .padPu(padPu),
    .padPd(padPd), .gpioIn(gpioIn), .funcIn(funcIn)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = AW'(addr); wrData = DW'(data);
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  // drive pad p with value v on function s, inverse on every other source
  task automatic driveFn(input int p, input int s, input logic o, input logic e);
    gpioOut = {P{~o}}; gpioOe = {P{~e}};
    altOut  = {3*P{~o}}; altOe = {3*P{~e}};
    if (s == 0) begin gpioOut[p] = o; gpioOe[p] = e; end
    else begin altOut[(s-1)*P + p] = o; altOe[(s-1)*P + p] = e; end
    #1;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin : stim
    padIn = '1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;

    // R10 reset state
    chk("R10 padOe", padOe, 0);
    chk("R10 padPu", padPu, 0);
    chk("R10 padPd", padPd, 0);
    chk("R10 gpioIn bypass", gpioIn, 4'hF);
    // R7 unwritten inputs gated
    chk("R7 funcIn gated", funcIn, 0);
    driveFn(0, 0, 1'b1, 1'b1);
    chk("R10 GPIO released despite gpioOe", padOe, 0);

    // R1 R2 R3 R4 exhaustive output sweep
    for (int p = 0; p < P; p++) begin
      for (int s = 0; s < 4; s++) begin
        for (int m = 0; m < 4; m++) begin
          wr(p, (m << 2) | s);
          for (int v = 0; v < 4; v++) begin
            logic o, e, eo, ee;
            string tag;
            o = v[0]; e = v[1];
            driveFn(p, s, o, e);
            if (m == 1) begin eo = o; ee = e; tag = "R1 R2 push-pull"; end
            else if (m == 2) begin eo = 1'b0; ee = e & ~o; tag = "R1 R3 open-drain"; end
            else begin eo = 1'b0; ee = 1'b0; tag = "R4 released"; end
            chk($sformatf("%s pad%0d sel%0d mode%0d out", tag, p, s, m), padOut[p], eo);
            chk($sformatf("%s pad%0d sel%0d mode%0d oe", tag, p, s, m), padOe[p], ee);
          end
        end
      end
      wr(p, 0);
    end

    // R5 pull sweep
    for (int p = 0; p < P; p++) begin
      for (int u = 0; u < 2; u++) begin
        for (int d = 0; d < 2; d++) begin
          wr(p, (u << 4) | (d << 5));
          chk($sformatf("R5 pad%0d pu u%0d d%0d", p, u, d), padPu[p], u);
          chk($sformatf("R5 pad%0d pd u%0d d%0d", p, u, d), padPd[p], d & ~u);
        end
      end
      wr(p, 0);
    end

    // R6 input selectors, R7 gating on the rest
    for (int f = 0; f < NI; f++) begin
      wr(P + f, (f + 1) % P);
      for (int g = f + 1; g < NI; g++) begin
        padIn = '1; #1;
        chk($sformatf("R7 func%0d still gated", g), funcIn[g], 0);
      end
    end
    for (int pat = 0; pat < 16; pat++) begin
      padIn = 4'(pat); #1;
      for (int f = 0; f < NI; f++)
        chk($sformatf("R6 R8 func%0d pat%0h", f, pat), funcIn[f], pat[(f + 1) % P]);
      chk($sformatf("R8 gpioIn pat%0h", pat), gpioIn, pat);
    end

    // R9 debounce on pad 1, divider 0 (tick every cycle)
    padIn = '0;
    wr(1, 32'h40);
    edges(4);
    chk("R9 settled low", gpioIn[1], 0);
    @(negedge clk); padIn[1] = 1'b1;
    edges(2);
    chk("R9 two samples only", gpioIn[1], 0);
    chk("R9 func0 follows filtered", funcIn[0], 0);
    edges(1);
    chk("R9 third sample", gpioIn[1], 1);
    chk("R9 func0 follows filtered", funcIn[0], 1);
    @(negedge clk); padIn[1] = 1'b0;
    @(negedge clk); padIn[1] = 1'b1;
    edges(4);
    chk("R9 one-cycle glitch ignored", gpioIn[1], 1);
    chk("R8 pad2 bypass", gpioIn[2], 0);
    padIn[2] = 1'b1; #1;
    chk("R8 pad2 bypass no edge", gpioIn[2], 1);

    // R9 divider 3 -> tick every 4 cycles
    wr(P + NI, 3);
    edges(8);
    @(negedge clk); padIn[1] = 1'b0;
    edges(7);
    chk("R9 div3 early", gpioIn[1], 1);
    edges(5);
    chk("R9 div3 settled", gpioIn[1], 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule